// File: doc/BRIEF.md
# Stepped System Tick Timer

The block keeps a 64-bit tick count that advances on every clock by a programmable step. There are two step values. One is used while the timer runs from the fast PLL-derived clock and one while it runs from the slower crystal-derived clock. With the right steps, the count advances by the same number of ticks per microsecond whichever clock is in use. The reset steps are 1 and 2. These suit an 80 MHz fast clock and a 40 MHz crystal. The crystal step can be rewritten when the crystal clock is divided down; a 10 MHz clock, for example, needs a step of 8.

Software works through a flat word-addressed register port. To read the count, software writes a capture request, polls a valid flag, and then reads two 32-bit halves that were latched in one cycle. To change the count, software stages a new value in two load words and writes an apply strobe. The block has one alarm comparator. The alarm fires in one-shot or periodic mode and sets a sticky interrupt flag.

Top module: `sys_tick_timer`

## Requirements
- R1: After reset the following hold. The count, the snapshot, the load words, the alarm target and the alarm period are zero. The valid flag, alarm enable, periodic mode and `irq` are 0. The fast step reads 1 and the slow step reads 2.
- R2: On every clock without an apply, the count grows by the fast step when the sampled source is 0 and by the slow step when it is 1. The count wraps modulo 2^64, and carries pass from the low half into the high half.
- R3: `clk_sel` is registered. A change made before edge k takes effect on the increment at edge k+1, and the count is never held back or reset by the change.
- R4: Writing 1 to bit 0 of CTRL (address 0) is a capture request. Valid (CTRL read bit 0) is 0 after the request edge and 1 one edge later. SNAP_LO and SNAP_HI (addresses 1 and 2) then hold the count as it stood just after the request edge.
- R5: LOAD_LO and LOAD_HI (addresses 3 and 4) have no effect on the count until 1 is written to bit 1 of CTRL. The count then equals the staged value on the following cycle and keeps counting from there.
- R6: FAST_STEP and SLOW_STEP (addresses 5 and 6, low 8 bits) are read/write. A new value is used from the increment after the write edge.
- R7: While the alarm is enabled and the count is greater than or equal to the target, the sticky flag `irq` (STAT bit 0, address 12) is set on the next edge. Writing 1 to STAT bit 0 clears the flag, but a new hit in the same cycle wins.
- R8: When ALM_CFG bit 0 (enable, address 7) is 0, `irq` is never set, even when the count is past the target.
- R9: In one-shot mode (ALM_CFG bit 1 = 0), a hit clears the enable bit.
- R10: In periodic mode (ALM_CFG bit 1 = 1), a hit adds PER_LO/PER_HI (addresses 10 and 11) to the target (TGT_LO/TGT_HI, addresses 8 and 9), and the alarm stays enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_sel | input | 1 | Timebase in use: 0 fast PLL, 1 crystal |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write word address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 4 | Read word address |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| irq | output | 1 | Sticky alarm interrupt flag |

## Verification
Some properties are checked on every cycle. Valid drops after each capture request and rises once the pending capture completes. `irq` never rises unless the alarm was armed, and it stays set until it is cleared. After a hit, the enable bit is cleared in one-shot mode and kept in periodic mode. Only the bench's scenarios can show that the captured values track the accumulated count across step rewrites, source changes, loads that have not been applied, and wraps from the low half into the high half. The same holds for the exact cycle each alarm fires and for the target reached after periodic advances.

// File: rtl/sys_tick_timer.sv
module sys_tick_timer #(
  parameter int DATA_W = 32,
  parameter int STEP_W = 8,
  parameter int ADDR_W = 4,
  parameter int FAST_STEP_RST = 1,
  parameter int SLOW_STEP_RST = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_sel,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq
);
  localparam int CNT_W = 2 * DATA_W;
  localparam logic [ADDR_W-1:0] A_CTRL = 0, A_SNAP_LO = 1, A_SNAP_HI = 2,
    A_LOAD_LO = 3, A_LOAD_HI = 4, A_STEP_F = 5, A_STEP_S = 6, A_CFG = 7,
    A_TGT_LO = 8, A_TGT_HI = 9, A_PER_LO = 10, A_PER_HI = 11, A_STAT = 12;

  logic [CNT_W-1:0]  cnt, snap, load, tgt, per;
  logic [STEP_W-1:0] step_f, step_s;
  logic              src_q, snap_pend, snap_valid, alm_en, periodic;

  function automatic logic wsel(input logic [ADDR_W-1:0] a);
    return wr_en && (wr_addr == a);
  endfunction

  wire snap_req = wsel(A_CTRL) && wr_data[0];
  wire apply    = wsel(A_CTRL) && wr_data[1];
  wire cfg_wr   = wsel(A_CFG);
  wire clr_wr   = wsel(A_STAT) && wr_data[0];
  wire hit      = alm_en && (cnt >= tgt);
  wire [STEP_W-1:0] step = src_q ? step_s : step_f;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      src_q <= 1'b0;
    end else begin
      cnt   <= apply ? load : cnt + CNT_W'(step);
      src_q <= clk_sel;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      snap       <= '0;
      snap_pend  <= 1'b0;
      snap_valid <= 1'b0;
    end else if (snap_req) begin
      snap_pend  <= 1'b1;
      snap_valid <= 1'b0;
    end else if (snap_pend) begin
      snap       <= cnt;
      snap_pend  <= 1'b0;
      snap_valid <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      load   <= '0;
      per    <= '0;
      step_f <= STEP_W'(FAST_STEP_RST);
      step_s <= STEP_W'(SLOW_STEP_RST);
    end else begin
      if (wsel(A_LOAD_LO)) load[DATA_W-1:0]     <= wr_data;
      if (wsel(A_LOAD_HI)) load[CNT_W-1:DATA_W] <= wr_data;
      if (wsel(A_PER_LO))  per[DATA_W-1:0]      <= wr_data;
      if (wsel(A_PER_HI))  per[CNT_W-1:DATA_W]  <= wr_data;
      if (wsel(A_STEP_F))  step_f <= wr_data[STEP_W-1:0];
      if (wsel(A_STEP_S))  step_s <= wr_data[STEP_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tgt      <= '0;
      alm_en   <= 1'b0;
      periodic <= 1'b0;
      irq      <= 1'b0;
    end else begin
      if (hit) begin
        if (periodic) tgt <= tgt + per;
        else alm_en <= 1'b0;
      end
      if (wsel(A_TGT_LO)) tgt[DATA_W-1:0]     <= wr_data;
      if (wsel(A_TGT_HI)) tgt[CNT_W-1:DATA_W] <= wr_data;
      if (cfg_wr) begin
        alm_en   <= wr_data[0];
        periodic <= wr_data[1];
      end
      irq <= hit | (irq & ~clr_wr);
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_CTRL:    rd_data = DATA_W'(snap_valid);
      A_SNAP_LO: rd_data = snap[DATA_W-1:0];
      A_SNAP_HI: rd_data = snap[CNT_W-1:DATA_W];
      A_LOAD_LO: rd_data = load[DATA_W-1:0];
      A_LOAD_HI: rd_data = load[CNT_W-1:DATA_W];
      A_STEP_F:  rd_data = DATA_W'(step_f);
      A_STEP_S:  rd_data = DATA_W'(step_s);
      A_CFG:     rd_data = DATA_W'({periodic, alm_en});
      A_TGT_LO:  rd_data = tgt[DATA_W-1:0];
      A_TGT_HI:  rd_data = tgt[CNT_W-1:DATA_W];
      A_PER_LO:  rd_data = per[DATA_W-1:0];
      A_PER_HI:  rd_data = per[CNT_W-1:DATA_W];
      A_STAT:    rd_data = DATA_W'(irq);
      default:   rd_data = '0;
    endcase
  end

  a_r4_valid_drops: assert property (@(posedge clk) disable iff (!rst_n)
    snap_req |=> !snap_valid);
  a_r4_valid_rises: assert property (@(posedge clk) disable iff (!rst_n)
    (snap_pend && !snap_req) |=> snap_valid);
  a_r8_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(alm_en));
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !clr_wr) |=> irq);
  a_r9_oneshot_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !periodic && !cfg_wr) |=> !alm_en);
  a_r10_periodic_armed: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && periodic && !cfg_wr) |=> alm_en);
endmodule

// File: tb/sys_tick_timer_tb.sv
`timescale 1ns/100ps
module sys_tick_timer_tb_top;
  logic clk = 0, rst_n = 0, clk_sel = 0, wr_en = 0, irq;
  logic [3:0] wr_addr = 0, rd_addr = 0;
  logic [31:0] wr_data = 0, rd_data;
  int errors = 0, checks = 0;
  bit model_on = 0;

  always #2.5 clk = ~clk;

  sys_tick_timer dut_i (.clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq));

  logic [63:0] m_cnt, m_load, m_tgt, m_per, nc;
  logic [7:0]  m_sf, m_ss;
  logic        m_src, m_en, m_perd, m_fired, hit;
  logic [63:0] exp_q[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_load = 0; m_tgt = 0; m_per = 0; m_sf = 1; m_ss = 2;
      m_src = 0; m_en = 0; m_perd = 0; m_fired = 0;
    end else begin
      hit = m_en && (m_cnt >= m_tgt);
      nc = (wr_en && wr_addr == 0 && wr_data[1]) ? m_load : m_cnt + 64'(m_src ? m_ss : m_sf);
      if (wr_en && wr_addr == 0 && wr_data[0]) exp_q.push_back(nc);
      m_cnt = nc; m_src = clk_sel;
      if (hit) begin
        if (m_perd) m_tgt = m_tgt + m_per; else m_en = 0;
      end
      m_fired = hit | (m_fired & ~(wr_en && wr_addr == 12 && wr_data[0]));
      if (wr_en) case (wr_addr)
        3: m_load[31:0] = wr_data;   4: m_load[63:32] = wr_data;
        5: m_sf = wr_data[7:0];      6: m_ss = wr_data[7:0];
        7: begin m_en = wr_data[0]; m_perd = wr_data[1]; end
        8: m_tgt[31:0] = wr_data;    9: m_tgt[63:32] = wr_data;
        10: m_per[31:0] = wr_data;   11: m_per[63:32] = wr_data;
        default: ;
      endcase
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // R7 monitor: irq tracks the model every cycle
  always @(negedge clk) if (model_on) check("R7 irq", 64'(irq), 64'(m_fired));

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    rd_addr = a; #0.5; d = rd_data;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic snap_check(input string req);
    logic [31:0] v, lo, hi;
    wr(0, 1);
    rd(0, v); check("R4 valid drops", 64'(v[0]), 64'(0));
    @(negedge clk);
    rd(0, v); check("R4 valid rises", 64'(v[0]), 64'(1));
    rd(1, lo); rd(2, hi);
    if (exp_q.size() == 0) check({req, " no expected snapshot"}, 64'(1), 64'(0));
    else check(req, {hi, lo}, exp_q.pop_front());
  endtask

  initial begin
    #200_000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    idle(3); rst_n = 1; model_on = 1; @(negedge clk);
    // R1 reset state
    rd(0, v); check("R1 valid", 64'(v), 0);
    rd(5, v); check("R1 fast step", 64'(v), 1);
    rd(6, v); check("R1 slow step", 64'(v), 2);
    rd(7, v); check("R1 cfg", 64'(v), 0);
    rd(8, v); check("R1 target", 64'(v), 0);
    rd(12, v); check("R1 stat", 64'(v), 0);
    idle(20); snap_check("R2 fast step count");
    clk_sel = 1; idle(15); snap_check("R2 slow step count");
    for (int k = 0; k < 6; k++) begin
      clk_sel = ~clk_sel; idle(k + 1); snap_check("R3 source switch");
    end
    wr(6, 8); idle(10); snap_check("R6 slow step 8");
    wr(5, 3); clk_sel = 0; idle(7); snap_check("R6 fast step 3");
    wr(3, 32'hFFFF_FFF0); wr(4, 32'h0000_0001); idle(5);
    snap_check("R5 load not applied");
    wr(0, 2); snap_check("R5 after apply");
    wr(3, 32'hFFFF_FFF8); wr(4, 0); wr(0, 2); idle(4);
    snap_check("R2 carry into high half");
    // R8 disabled alarm with count past target
    wr(8, 5); wr(9, 0); wr(7, 0); idle(20);
    check("R8 disabled no irq", 64'(irq), 0);
    // R9 one-shot
    wr(5, 1); wr(8, m_cnt[31:0] + 60); wr(9, m_cnt[63:32]); wr(7, 1);
    for (int i = 0; i < 200 && !irq; i++) @(negedge clk);
    check("R7 one-shot fired", 64'(irq), 1);
    rd(7, v); check("R9 enable cleared", 64'(v), 0);
    idle(5); wr(12, 1); check("R7 cleared", 64'(irq), 0);
    idle(10); check("R9 no refire", 64'(irq), 0);
    // R10 periodic
    wr(3, 0); wr(4, 0); wr(0, 2);
    wr(10, 25); wr(11, 0); wr(8, 40); wr(9, 0); wr(7, 3);
    for (int n = 0; n < 4; n++) begin
      for (int i = 0; i < 200 && !irq; i++) @(negedge clk);
      check("R10 periodic fired", 64'(irq), 1);
      wr(12, 1);
    end
    rd(7, v); check("R10 still armed", 64'(v), 3);
    rd(8, v); check("R10 target advanced", 64'(v), 64'(m_tgt[31:0]));
    check("R10 target sanity", 64'(m_tgt), 64'(40 + 25 * 4));
    wr(7, 0); wr(12, 1); idle(3);
    model_on = 0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule